// File: doc/BRIEF.md
# Interpolated Polyphase Coefficient Generator

This block supplies coefficients to a 64-tap resampling FIR filter whose phase grid has 2^20 steps between neighbouring input samples. A full polyphase table for that grid would need 2^26 words. Instead, the block keeps a prototype impulse response of four points per tap, 256 entries in all. It spreads those entries over four parallel banks. On each request it rebuilds the coefficient it needs by cubic (Catmull-Rom) interpolation across four consecutive entries, one from each bank. The interpolation is evaluated in Horner form.

A request carries a tap number, a 20-bit sub-sample phase and a rate word. When the output rate is below the input rate, the rate word (fout/fin as an unsigned fraction) shrinks the lookup position. This stretches the impulse response and lowers the cutoff. Requests and results use a valid/ready handshake. The block accepts one request per cycle and returns each result after a fixed four-cycle latency. Under backpressure the whole pipeline freezes.

Top module: `poly_coef_gen`

## Requirements
- R1: For position x (26 bits), let i = x[25:18], T = x[17:2], and y0..y3 = P(i-1)..P(i+2). Let A = 3(y1-y2)+y3-y0, B = 2y0-5y1+4y2-y3 and C = y2-y0. Then u = floor(A*T/2^16)+B, v = floor(u*T/2^16)+C, and the result is y1+floor(v*T/2^17), saturated per R4.
- R2: When T = 0, the result equals the stored entry P(i) exactly.
- R3: Stored entries: P(n) = 0 for n<0 or n>255; P(128) = 8388607; P(136) = -8388608. Otherwise P(n) = n*(256-n)*511, negated when bit 2 of n is 1.
- R4: A result above 8388607 is returned as 8388607. A result below -8388608 is returned as -8388608. `coef_data` is 24-bit two's complement.
- R5: With `req_rate` = 0, x = req_tap*2^20 + req_phase. Otherwise x = floor((req_tap*2^20 + req_phase) * req_rate / 2^16).
- R6: With `coef_ready` held high, a request accepted at a rising edge gives `coef_valid` high after the fourth rising edge, counting the accepting edge. Back-to-back requests give one result per cycle.
- R7: While `coef_valid` is high and `coef_ready` is low, `req_ready` is low and `coef_data` holds. No accepted request is lost or reordered.
- R8: After synchronous active-high reset, `coef_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_tap | input | 6 | Tap number |
| req_phase | input | 20 | Sub-sample phase |
| req_rate | input | 16 | Stretch fraction fout/fin; 0 selects no stretch |
| coef_valid | output | 1 | Result present |
| coef_ready | input | 1 | Consumer takes the result |
| coef_data | output | 24 | Signed coefficient |

## Verification
A fresh request can arrive in the same cycle that the consumer withholds `coef_ready`. The freeze must then block acceptance and hold every stage, so the request is neither dropped nor issued twice. The bench provokes this by toggling `coef_ready` in an irregular pattern while it sends requests back to back. It then judges three things: `req_ready` stays low while a result is held, the held word never changes, and every expected value emerges in order. Saturated results also sit on the output during stalls, so a clamped word and a freeze can coincide.

// File: rtl/coefgen_pkg.sv
`timescale 1ns/1ps
package coefgen_pkg;
  localparam int ACC_W  = 40;
  localparam int PROD_W = 64;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [PROD_W-1:0] prod_t;

  typedef struct packed {
    acc_t cub;
    acc_t quad;
    acc_t lin;
  } cr_poly_t;

  // prototype entry n of a table with 'entries' points; lobes flip every 2^lobe_sh entries
  function automatic acc_t proto_val(int n, int entries, int lobe_sh, int w);
    longint half, maxv, scale, base;
    if (n < 0 || n >= entries) return '0;
    half  = longint'(entries / 2);
    maxv  = (longint'(1) << (w - 1)) - 1;
    scale = maxv / (half * half);
    if (longint'(n) == half) return acc_t'(maxv);
    if (longint'(n) == half + 2 * (longint'(1) << lobe_sh)) return acc_t'(-maxv - 1);
    base = longint'(n) * longint'(entries - n) * scale;
    if (((n >> lobe_sh) & 1) == 1) return acc_t'(-base);
    return acc_t'(base);
  endfunction

  // Catmull-Rom polynomial terms, all doubled
  function automatic cr_poly_t cr_poly(acc_t p0, acc_t p1, acc_t p2, acc_t p3);
    cr_poly_t r;
    r.cub  = (p1 - p2) + (p1 - p2) + (p1 - p2) + p3 - p0;
    r.quad = p0 + p0 - ((p1 <<< 2) + p1) + (p2 <<< 2) - p3;
    r.lin  = p2 - p0;
    return r;
  endfunction

  // one Horner step: floor(acc * frac / 2^sh) + add
  function automatic acc_t horner(acc_t acc, logic [31:0] frac, int unsigned sh, acc_t add);
    prod_t pr;
    pr = prod_t'(acc) * prod_t'({1'b0, frac});
    return acc_t'(pr >>> sh) + add;
  endfunction

  function automatic acc_t clamp(acc_t v, acc_t lo, acc_t hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/coef_bank.sv
`timescale 1ns/1ps
module coef_bank import coefgen_pkg::*; #(
  parameter int BANK    = 0,
  parameter int ROWS    = 65,
  parameter int ROW_W   = 7,
  parameter int ENTRIES = 256,
  parameter int LOBE_SH = 2,
  parameter int COEF_W  = 24
) (
  input  logic [ROW_W-1:0]         row,
  output logic signed [COEF_W-1:0] word
);
  // row r holds stored entry 4r+BANK-1 (one guard entry below index 0)
  logic signed [COEF_W-1:0] rom [ROWS];

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      rom[r] = COEF_W'(proto_val(4 * r + BANK - 1, ENTRIES, LOBE_SH, COEF_W));
    end
  end

  always_comb begin
    word = '0;
    if (32'(row) < ROWS) word = rom[row];
  end
endmodule

// File: rtl/coef_fetch.sv
`timescale 1ns/1ps
module coef_fetch #(
  parameter int IDX_W   = 8,
  parameter int LOBE_SH = 2,
  parameter int COEF_W  = 24
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [COEF_W-1:0] pt [4]
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int ROWS    = (ENTRIES + 2) / 4 + 1;
  localparam int ROW_W   = $clog2(ROWS);

  logic signed [COEF_W-1:0] bank_q [4];

  // point j (entry idx-1+j) is stored at slot idx+j, in bank (idx+j) mod 4
  for (genvar b = 0; b < 4; b++) begin : g_bank
    logic [1:0]       off;
    logic [IDX_W:0]   slot;
    logic [ROW_W-1:0] row;
    assign off  = 2'(b) - idx[1:0];
    assign slot = (IDX_W+1)'(idx) + (IDX_W+1)'(off);
    assign row  = ROW_W'(slot >> 2);
    coef_bank #(
      .BANK(b), .ROWS(ROWS), .ROW_W(ROW_W), .ENTRIES(ENTRIES),
      .LOBE_SH(LOBE_SH), .COEF_W(COEF_W)
    ) u_bank (
      .row (row),
      .word(bank_q[b])
    );
  end

  for (genvar j = 0; j < 4; j++) begin : g_rot
    assign pt[j] = bank_q[2'(idx[1:0] + 2'(j))];
  end
endmodule

// File: rtl/coef_horner.sv
`timescale 1ns/1ps
module coef_horner import coefgen_pkg::*; #(
  parameter int COEF_W = 24,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic                     in_v,
  input  logic signed [COEF_W-1:0] pt [4],
  input  logic [FRAC_W-1:0]        frac,
  output logic                     out_v,
  output logic signed [COEF_W-1:0] out_coef
);
  localparam acc_t C_MAX = acc_t'((longint'(1) << (COEF_W - 1)) - 1);
  localparam acc_t C_MIN = -C_MAX - acc_t'(1);

  // stage 3: polynomial terms and first Horner step
  cr_poly_t poly;
  acc_t     step1;
  assign poly  = cr_poly(acc_t'(pt[0]), acc_t'(pt[1]), acc_t'(pt[2]), acc_t'(pt[3]));
  assign step1 = horner(poly.cub, 32'(frac), FRAC_W, poly.quad);

  logic              s3_v;
  acc_t              s3_u, s3_lin, s3_y1;
  logic [FRAC_W-1:0] s3_t;

  always_ff @(posedge clk) begin
    if (rst) s3_v <= 1'b0;
    else if (adv) s3_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s3_u   <= step1;
      s3_lin <= poly.lin;
      s3_y1  <= acc_t'(pt[1]);
      s3_t   <= frac;
    end
  end

  // stage 4: remaining steps, halving, offset and saturation
  acc_t step2, raw, sat_val;
  logic clip_hi, clip_lo;
  assign step2   = horner(s3_u, 32'(s3_t), FRAC_W, s3_lin);
  assign raw     = horner(step2, 32'(s3_t), FRAC_W + 1, s3_y1);
  assign clip_hi = raw > C_MAX;
  assign clip_lo = raw < C_MIN;
  assign sat_val = clamp(raw, C_MIN, C_MAX);

  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else if (adv) out_v <= s3_v;
  end

  always_ff @(posedge clk) begin
    if (adv) out_coef <= COEF_W'(sat_val);
  end

  a_r2_knot_exact: assert property (@(posedge clk) disable iff (rst)
    adv && s3_v && (s3_t == '0) |=> acc_t'(out_coef) == $past(s3_y1));
  a_r4_clip_high: assert property (@(posedge clk) disable iff (rst)
    adv && s3_v && clip_hi |=> acc_t'(out_coef) == C_MAX);
  a_r4_clip_low: assert property (@(posedge clk) disable iff (rst)
    adv && s3_v && clip_lo |=> acc_t'(out_coef) == C_MIN);
  a_r6_last_stage: assert property (@(posedge clk) disable iff (rst)
    adv |=> out_v == $past(s3_v));
endmodule

// File: rtl/poly_coef_gen.sv
`timescale 1ns/1ps
module poly_coef_gen import coefgen_pkg::*; #(
  parameter int TAPS     = 64,
  parameter int PHASE_W  = 20,
  parameter int PTS_LOG2 = 2,
  parameter int FRAC_W   = 16,
  parameter int COEF_W   = 24,
  parameter int RATE_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(TAPS)-1:0]  req_tap,
  input  logic [PHASE_W-1:0]       req_phase,
  input  logic [RATE_W-1:0]        req_rate,
  output logic                     coef_valid,
  input  logic                     coef_ready,
  output logic [COEF_W-1:0]        coef_data
);
  localparam int TAP_W   = $clog2(TAPS);
  localparam int POS_W   = TAP_W + PHASE_W;
  localparam int IDX_W   = TAP_W + PTS_LOG2;
  localparam int SUB_W   = PHASE_W - PTS_LOG2;
  localparam int DROP_W  = SUB_W - FRAC_W;
  localparam int PROD_PW = POS_W + RATE_W;

  function automatic logic [POS_W-1:0] stretch(logic [POS_W-1:0] x, logic [RATE_W-1:0] r);
    logic [PROD_PW-1:0] m;
    if (r == '0) return x;
    m = PROD_PW'(x) * PROD_PW'(r);
    return POS_W'(m >> RATE_W);
  endfunction

  // global freeze while a result waits
  logic adv, req_fire;
  assign adv       = !(coef_valid && !coef_ready);
  assign req_ready = adv;
  assign req_fire  = req_valid && req_ready;

  // stage 1: stretched lookup position
  logic             s1_v;
  logic [POS_W-1:0] s1_pos;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else if (adv) s1_v <= req_fire;
  end

  always_ff @(posedge clk) begin
    if (adv) s1_pos <= stretch({req_tap, req_phase}, req_rate);
  end

  logic [IDX_W-1:0]  s1_idx;
  logic [FRAC_W-1:0] s1_frac;
  assign s1_idx  = IDX_W'(s1_pos >> SUB_W);
  assign s1_frac = FRAC_W'(s1_pos >> DROP_W);

  // stage 2: four neighbouring stored points
  logic signed [COEF_W-1:0] f_pt [4];
  coef_fetch #(.IDX_W(IDX_W), .LOBE_SH(PTS_LOG2), .COEF_W(COEF_W)) u_fetch (
    .idx(s1_idx),
    .pt (f_pt)
  );

  logic                     s2_v;
  logic signed [COEF_W-1:0] s2_pt [4];
  logic [FRAC_W-1:0]        s2_frac;

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else if (adv) s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int j = 0; j < 4; j++) s2_pt[j] <= f_pt[j];
      s2_frac <= s1_frac;
    end
  end

  // stages 3 and 4
  logic signed [COEF_W-1:0] h_coef;
  coef_horner #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_horner (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .in_v    (s2_v),
    .pt      (s2_pt),
    .frac    (s2_frac),
    .out_v   (coef_valid),
    .out_coef(h_coef)
  );
  assign coef_data = h_coef;

  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    coef_valid && !coef_ready |=> coef_valid && $stable(coef_data));
  a_r6_enter_pipe: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> s1_v);
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> !coef_valid && !s1_v && !s2_v);
endmodule

// File: tb/sim_poly_coef_gen.sv
`timescale 1ns/1ps
module sim_poly_coef_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_tap = '0;
  logic [19:0] req_phase = '0;
  logic [15:0] req_rate = '0;
  logic        coef_valid;
  logic        coef_ready = 1'b1;
  logic [23:0] coef_data;

  poly_coef_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tap(req_tap), .req_phase(req_phase), .req_rate(req_rate),
    .coef_valid(coef_valid), .coef_ready(coef_ready), .coef_data(coef_data)
  );

  always #2.5 clk = ~clk;

  int     n_chk = 0;
  int     n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint exp_q[$];
  string  tag_q[$];
  longint acc_q[$];
  bit     lat_on = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stored prototype restated (R3)
  function automatic longint bp(longint n);
    longint m;
    if (n < 0 || n > 255) return 0;
    if (n == 128) return 8388607;
    if (n == 136) return -8388608;
    m = n * (256 - n) * 511;
    return (((n >> 2) & 1) == 1) ? -m : m;
  endfunction

  // expected coefficient (R1, R4, R5)
  function automatic longint model(int tap, int ph, int rate);
    longint x, i, t, y0, y1, y2, y3, a, b, c, u, v, f;
    x = longint'(tap) * 1048576 + longint'(ph);
    if (rate != 0) x = (x * longint'(rate)) / 65536;
    i = x / 262144;
    t = (x / 4) % 65536;
    y0 = bp(i - 1); y1 = bp(i); y2 = bp(i + 1); y3 = bp(i + 2);
    a = 3 * (y1 - y2) + y3 - y0;
    b = 2 * y0 - 5 * y1 + 4 * y2 - y3;
    c = y2 - y0;
    u = ((a * t) >>> 16) + b;
    v = ((u * t) >>> 16) + c;
    f = ((v * t) >>> 17) + y1;
    if (f > 8388607) f = 8388607;
    if (f < -8388608) f = -8388608;
    return f;
  endfunction

  // output monitor: ordering, values, hold under stall
  logic        prev_blk = 1'b0;
  logic [23:0] prev_data = '0;
  longint      m_e, m_a;
  string       m_t;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_blk) begin
        chk("R7 valid kept while stalled", longint'(coef_valid), 1);
        chk("R7 data kept while stalled", longint'(coef_data), longint'(prev_data));
      end
      if (coef_valid && !coef_ready) chk("R7 req_ready low while stalled", longint'(req_ready), 0);
      if (coef_valid && coef_ready) begin
        if (exp_q.size() == 0) chk("R7 output without request", 1, 0);
        else begin
          m_e = exp_q.pop_front();
          m_t = tag_q.pop_front();
          m_a = acc_q.pop_front();
          chk(m_t, longint'($signed(coef_data)), m_e);
          if (lat_on) chk("R6 latency", cyc - m_a, 4);
        end
      end
      prev_blk  = coef_valid && !coef_ready;
      prev_data = coef_data;
    end
  end

  task automatic send(int tap, int ph, int rate, string tag);
    req_tap = 6'(tap); req_phase = 20'(ph); req_rate = 16'(rate); req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(model(tap, ph, rate));
    tag_q.push_back(tag);
    acc_q.push_back(cyc);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 60 && exp_q.size() > 0; i++) @(posedge clk);
    #1;
    chk(tag, longint'(exp_q.size()), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 coef_valid after reset", longint'(coef_valid), 0);
    chk("R8 req_ready after reset", longint'(req_ready), 1);
    @(posedge clk); #1;
  endtask

  task automatic t_knots();
    send(0, 0, 0, "R2 R3 knot entry 0");
    send(32, 0, 0, "R2 R3 knot positive peak");
    send(34, 0, 0, "R2 R3 knot negative peak");
    send(63, 20'hC0000, 0, "R2 R3 knot last entry");
    send(5, 20'h40000, 0, "R2 R3 knot inside lobe");
    drain("R7 knots delivered");
    chk("R3 model peak entry", bp(128), 8388607);
  endtask

  task automatic t_sweep();
    send(0, 20'h00004, 0, "R1 first segment");
    send(7, 20'h12345, 0, "R1 mid phase");
    send(16, 20'h3FFFF, 0, "R1 end of segment");
    send(31, 20'hABCDE, 0, "R1 lobe boundary");
    send(40, 20'h80000, 0, "R1 half tap");
    send(63, 20'hFFFFF, 0, "R1 last phase");
    send(50, 20'h0F0F0, 0, "R1 pattern phase");
    drain("R7 sweep delivered");
  endtask

  task automatic t_sat();
    send(32, 20'h10000, 0, "R4 positive clamp");
    send(33, 20'hF0000, 0, "R4 negative clamp");
    drain("R7 sat delivered");
    chk("R4 positive case reaches limit", model(32, 20'h10000, 0), 8388607);
    chk("R4 negative case reaches limit", model(33, 20'hF0000, 0), -8388608);
  endtask

  task automatic t_rate();
    send(10, 0, 16'h8000, "R5 half rate knot");
    send(63, 20'hFFFFF, 16'hC000, "R5 three quarter rate");
    send(20, 20'h55555, 16'h0001, "R5 tiny rate");
    send(20, 20'h55555, 0, "R5 zero means unity");
    send(40, 20'h2468A, 16'hFFFF, "R5 near unity");
    drain("R7 rate delivered");
    chk("R5 half rate maps tap 10 to tap 5", model(10, 0, 16'h8000), model(5, 0, 0));
  endtask

  task automatic t_latency();
    lat_on = 1'b1;
    for (int k = 0; k < 6; k++) send(k * 9 + 3, k * 20'h1F3A1, 0, "R6 back to back value");
    drain("R6 burst delivered");
    lat_on = 1'b0;
  endtask

  task automatic t_backpressure();
    fork
      begin
        for (int k = 0; k < 16; k++) begin
          if (k == 4) send(32, 20'h10000, 0, "R7 R4 clamp under stall");
          else send(k * 4, k * 20'h0B3C7, (k % 3 == 0) ? 16'hA000 : 0, "R7 value under stall");
        end
      end
      begin
        for (int i = 0; i < 60; i++) begin
          @(posedge clk); #1;
          coef_ready = ((i % 5) != 1) && ((i % 7) != 3) && ((i % 11) != 6);
        end
        coef_ready = 1'b1;
      end
    join
    drain("R7 no request lost");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_knots();
    t_sweep();
    t_sat();
    t_rate();
    t_latency();
    t_backpressure();
    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule